// File: doc/BRIEF.md
# Instruction Decoder with Configuration Registers

The decoder sits in front of a tensor processing unit's execution units and consumes a stream of fixed-width instruction words over a valid/ready handshake. Each word is split into a 4-bit opcode in the most significant bits, a 4-bit flag nibble directly below it, and three operand fields packed from the least significant bit upward. Work instructions (matrix multiply, data move, weight load, vector ALU and lookup-table load) are registered and offered on a dispatch handshake, along with a decoded vector count and a decoded local-memory stride. The dispatch port also carries the raw fields.

Configure instructions never leave the decoder. They write a small register file that holds two DRAM window offsets with their cache attributes, a stall limit, a tracepoint, the program counter and a sample period. The DRAM offsets are exported as byte addresses. A NoOp or any unused opcode is consumed in the cycle it is accepted. The program counter advances once for every completed instruction. A stall watchdog raises a flag when the decoder state has not changed for the programmed number of cycles. A tracepoint flag is high whenever the program counter equals the tracepoint register.

Top module: `instr_decoder`

## Requirements
- R1: With default parameters a 64-bit word is split as opcode [63:60], flags [59:56], operand 2 [55:48], operand 1 [47:16] and operand 0 [15:0], and these fields appear unchanged on the dispatch port.
- R2: Opcodes 0x1 to 0x5 are accepted only while `in_ready` is high. Each is then offered on the dispatch port from the next cycle with `in_ready` low. The offer holds every field stable until the cycle in which `disp_ready` is high.
- R3: Opcode 0x0 and the unused opcodes 0x6 to 0xE are consumed in their accept cycle with no dispatch, and they count as completed.
- R4: Configure (opcode 0xF) writes the low bits of operand 1 into the register whose number is in operand 0. The register numbers are: 0x00 DRAM0 offset, 0x01 DRAM0 attribute (4 bits), 0x04 DRAM1 offset, 0x05 DRAM1 attribute, 0x08 stall limit (16 bits), 0x09 tracepoint, 0x0A program counter and 0x0B sample period (16 bits). A write to any other number changes no output.
- R5: After reset the stall limit is 100, the tracepoint is 0xFFFFFFFF, and every other register is 0.
- R6: Each DRAM base output equals its offset register shifted left by 16 bits, so the offset counts 64 KiB units.
- R7: The program counter increments by one, with wrap, at the edge where an instruction completes. A local instruction completes at acceptance and a dispatched one at its dispatch handshake. A Configure of register 0x0A loads the value with no extra increment.
- R8: `timeout_flag` rises at the edge where the decoder has held one state (idle or offering) for as many cycles as the stall limit. It drops at the next state change. A limit of 0 keeps it low.
- R9: `trace_flag` is high exactly when the program counter equals the tracepoint register.
- R10: `disp_vectors` is the size field plus one. The size field is operand 2 [7:0] for opcodes 0x1 and 0x2 and operand 1 [7:0] for opcode 0x3. The count is 1 for opcodes 0x4 and 0x5.
- R11: `disp_stride` equals 2 raised to the power of operand 0 [15:13], so a field of 0 gives 1 and a field of 7 gives 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can accept a word |
| in_instr | input | 64 | Instruction word |
| disp_valid | output | 1 | Work instruction offered to execution units |
| disp_ready | input | 1 | Execution units take the offer |
| disp_opcode | output | 4 | Opcode of offered instruction |
| disp_flags | output | 4 | Flag nibble |
| disp_op0 | output | 16 | Operand 0 |
| disp_op1 | output | 32 | Operand 1 |
| disp_op2 | output | 8 | Operand 2 |
| disp_vectors | output | 9 | Decoded transfer length in vectors |
| disp_stride | output | 8 | Decoded local-memory stride |
| dram0_base | output | 48 | DRAM0 window byte offset |
| dram0_cache | output | 4 | DRAM0 cache attribute |
| dram1_base | output | 48 | DRAM1 window byte offset |
| dram1_cache | output | 4 | DRAM1 cache attribute |
| sample_period | output | 16 | Sampling period register |
| prog_count | output | 32 | Program counter |
| timeout_flag | output | 1 | Stall watchdog flag |
| trace_flag | output | 1 | Tracepoint match |

## Verification
A vector table sends every work opcode with distinct flags, operand values, size fields at 0, 7 and 255, and stride fields from 0 to 7. These vectors tell a field slip or a wrong size source apart from an off-by-one in the length decode. The table also sends NoOp and both ends of the unused opcode range, so a decoder that dispatches them, or one that forgets to count them, shows up. Directed tests follow. They write every register and an unused register number, load the program counter at the wrap point and at the tracepoint, and stall an offer for exactly the limit. The stall test exposes the watchdog one cycle early or one cycle late.

// File: rtl/idec_pkg.sv
package idec_pkg;
   localparam logic [3:0] OPC_NOP    = 4'h0;
   localparam logic [3:0] OPC_MATMUL = 4'h1;
   localparam logic [3:0] OPC_MOVE   = 4'h2;
   localparam logic [3:0] OPC_WLOAD  = 4'h3;
   localparam logic [3:0] OPC_VALU   = 4'h4;
   localparam logic [3:0] OPC_TABLE  = 4'h5;
   localparam logic [3:0] OPC_CONFIG = 4'hF;

   localparam int unsigned REG_D0_OFF  = 0;
   localparam int unsigned REG_D0_ATTR = 1;
   localparam int unsigned REG_D1_OFF  = 4;
   localparam int unsigned REG_D1_ATTR = 5;
   localparam int unsigned REG_STALL   = 8;
   localparam int unsigned REG_TRACE   = 9;
   localparam int unsigned REG_PC      = 10;
   localparam int unsigned REG_SAMPLE  = 11;

   typedef enum logic {ST_IDLE, ST_ISSUE} dec_state_e;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
   import idec_pkg::*;
#(
   parameter int unsigned INSTR_W  = 64,
   parameter int unsigned OP0_W    = 16,
   parameter int unsigned OP1_W    = 32,
   parameter int unsigned OP2_W    = 8,
   parameter int unsigned SIZE_W   = 8,
   parameter int unsigned STRIDE_W = 3,
   localparam int unsigned LEN_W    = SIZE_W + 1,
   localparam int unsigned STRIDE_N = 1 << STRIDE_W,
   localparam int unsigned ADDR_W   = OP0_W - STRIDE_W
) (
   input  logic [INSTR_W-1:0]  instr,
   output logic [3:0]          opcode,
   output logic [3:0]          flags,
   output logic [OP0_W-1:0]    op0,
   output logic [OP1_W-1:0]    op1,
   output logic [OP2_W-1:0]    op2,
   output logic                is_issue,
   output logic                is_config,
   output logic [LEN_W-1:0]    vectors,
   output logic [STRIDE_N-1:0] stride
);
   logic [SIZE_W-1:0] size_fld;

   assign opcode = instr[INSTR_W-1 -: 4];
   assign flags  = instr[INSTR_W-5 -: 4];
   assign op0    = instr[0 +: OP0_W];
   assign op1    = instr[OP0_W +: OP1_W];
   assign op2    = instr[OP0_W+OP1_W +: OP2_W];

   always_comb begin
      is_issue  = 1'b0;
      is_config = (opcode == OPC_CONFIG);
      size_fld  = '0;
      unique case (opcode)
         OPC_MATMUL, OPC_MOVE: begin
            is_issue = 1'b1;
            size_fld = op2[SIZE_W-1:0];
         end
         OPC_WLOAD: begin
            is_issue = 1'b1;
            size_fld = op1[SIZE_W-1:0];
         end
         OPC_VALU, OPC_TABLE: is_issue = 1'b1;
         default: ;
      endcase
   end

   assign vectors = LEN_W'(size_fld) + LEN_W'(1);
   assign stride  = STRIDE_N'(1) << op0[ADDR_W +: STRIDE_W];
endmodule

// File: rtl/idec_regs.sv
module idec_regs
   import idec_pkg::*;
#(
   parameter int unsigned OP0_W      = 16,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned ATTR_W     = 4,
   parameter int unsigned TMO_W      = 16,
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned OFF_SHIFT  = 16,
   parameter int unsigned TMO_RESET  = 100,
   parameter bit          TRACE_PIPE = 1'b0,
   localparam int unsigned BASE_W    = CFG_W + OFF_SHIFT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [OP0_W-1:0]    wr_addr,
   input  logic [CFG_W-1:0]    wr_data,
   input  logic                step,
   output logic [BASE_W-1:0]   dram0_base,
   output logic [ATTR_W-1:0]   dram0_attr,
   output logic [BASE_W-1:0]   dram1_base,
   output logic [ATTR_W-1:0]   dram1_attr,
   output logic [TMO_W-1:0]    stall_limit,
   output logic [SAMPLE_W-1:0] sample_period,
   output logic [CFG_W-1:0]    pc,
   output logic                trace_hit
);
   logic [CFG_W-1:0] off0_q, off1_q, trace_q, pc_d;
   logic             pc_wr;

   assign pc_wr = wr_en && (wr_addr == OP0_W'(REG_PC));

   always_comb begin
      pc_d = pc;
      if (pc_wr)     pc_d = wr_data;
      else if (step) pc_d = pc + CFG_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off0_q        <= '0;
         off1_q        <= '0;
         dram0_attr    <= '0;
         dram1_attr    <= '0;
         stall_limit   <= TMO_W'(TMO_RESET);
         trace_q       <= '1;
         sample_period <= '0;
         pc            <= '0;
      end else begin
         pc <= pc_d;
         if (wr_en) begin
            if (wr_addr == OP0_W'(REG_D0_OFF))  off0_q        <= wr_data;
            if (wr_addr == OP0_W'(REG_D0_ATTR)) dram0_attr    <= wr_data[ATTR_W-1:0];
            if (wr_addr == OP0_W'(REG_D1_OFF))  off1_q        <= wr_data;
            if (wr_addr == OP0_W'(REG_D1_ATTR)) dram1_attr    <= wr_data[ATTR_W-1:0];
            if (wr_addr == OP0_W'(REG_STALL))   stall_limit   <= wr_data[TMO_W-1:0];
            if (wr_addr == OP0_W'(REG_TRACE))   trace_q       <= wr_data;
            if (wr_addr == OP0_W'(REG_SAMPLE))  sample_period <= wr_data[SAMPLE_W-1:0];
         end
      end
   end

   assign dram0_base = {off0_q, OFF_SHIFT'(0)};
   assign dram1_base = {off1_q, OFF_SHIFT'(0)};

   generate
      if (TRACE_PIPE) begin : g_trace_reg
         logic [CFG_W-1:0] trace_d;
         logic             hit_q;
         assign trace_d = (wr_en && wr_addr == OP0_W'(REG_TRACE)) ? wr_data : trace_q;
         always_ff @(posedge clk) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= (pc_d == trace_d);
         end
         assign trace_hit = hit_q;
      end else begin : g_trace_comb
         assign trace_hit = (pc == trace_q);
      end
   endgenerate

   p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step && !pc_wr |=> pc == CFG_W'($past(pc) + 1'b1));
   p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !pc_wr |=> $stable(pc));
   p_pc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr |=> pc == $past(wr_data));
endmodule

// File: rtl/idec_stall_watch.sv
module idec_stall_watch #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             state_chg,
   input  logic [TMO_W-1:0] limit,
   output logic             flag
);
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W:0]   cnt_nx;

   assign cnt_nx = {1'b0, cnt_q} + (TMO_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || state_chg) begin
         cnt_q <= '0;
         flag  <= 1'b0;
      end else begin
         if (cnt_q != '1) cnt_q <= cnt_nx[TMO_W-1:0];
         flag <= (limit != '0) && (flag || (cnt_nx >= {1'b0, limit}));
      end
   end

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_chg |=> !flag);
   p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      limit == '0 |=> !flag);
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
   import idec_pkg::*;
#(
   parameter int unsigned INSTR_W    = 64,
   parameter int unsigned OP0_W      = 16,
   parameter int unsigned OP1_W      = 32,
   parameter int unsigned OP2_W      = 8,
   parameter int unsigned SIZE_W     = 8,
   parameter int unsigned STRIDE_W   = 3,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned ATTR_W     = 4,
   parameter int unsigned TMO_W      = 16,
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned OFF_SHIFT  = 16,
   parameter int unsigned TMO_RESET  = 100,
   parameter bit          TRACE_PIPE = 1'b0,
   localparam int unsigned LEN_W     = SIZE_W + 1,
   localparam int unsigned STRIDE_N  = 1 << STRIDE_W,
   localparam int unsigned BASE_W    = CFG_W + OFF_SHIFT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [INSTR_W-1:0]  in_instr,
   output logic                disp_valid,
   input  logic                disp_ready,
   output logic [3:0]          disp_opcode,
   output logic [3:0]          disp_flags,
   output logic [OP0_W-1:0]    disp_op0,
   output logic [OP1_W-1:0]    disp_op1,
   output logic [OP2_W-1:0]    disp_op2,
   output logic [LEN_W-1:0]    disp_vectors,
   output logic [STRIDE_N-1:0] disp_stride,
   output logic [BASE_W-1:0]   dram0_base,
   output logic [ATTR_W-1:0]   dram0_cache,
   output logic [BASE_W-1:0]   dram1_base,
   output logic [ATTR_W-1:0]   dram1_cache,
   output logic [SAMPLE_W-1:0] sample_period,
   output logic [CFG_W-1:0]    prog_count,
   output logic                timeout_flag,
   output logic                trace_flag
);
   generate
      if (OP0_W + OP1_W + OP2_W > INSTR_W - 8) begin : g_bad_layout
         $error("instr_decoder: operands do not fit below opcode and flags");
      end
      if (OP1_W < CFG_W || SIZE_W > OP2_W || SIZE_W > OP1_W) begin : g_bad_width
         $error("instr_decoder: operand too narrow for value or size field");
      end
      if (STRIDE_W >= OP0_W) begin : g_bad_stride
         $error("instr_decoder: stride field does not fit in operand 0");
      end
   endgenerate

   logic [3:0]          f_opcode, f_flags;
   logic [OP0_W-1:0]    f_op0;
   logic [OP1_W-1:0]    f_op1;
   logic [OP2_W-1:0]    f_op2;
   logic                f_issue, f_config;
   logic [LEN_W-1:0]    f_vectors;
   logic [STRIDE_N-1:0] f_stride;
   logic [TMO_W-1:0]    stall_limit;
   dec_state_e          state_q, state_d;
   logic                accept, done;

   idec_fields #(
      .INSTR_W(INSTR_W), .OP0_W(OP0_W), .OP1_W(OP1_W), .OP2_W(OP2_W),
      .SIZE_W(SIZE_W), .STRIDE_W(STRIDE_W)
   ) u_fields (
      .instr(in_instr), .opcode(f_opcode), .flags(f_flags),
      .op0(f_op0), .op1(f_op1), .op2(f_op2),
      .is_issue(f_issue), .is_config(f_config),
      .vectors(f_vectors), .stride(f_stride)
   );

   assign in_ready   = (state_q == ST_IDLE);
   assign disp_valid = (state_q == ST_ISSUE);
   assign accept     = in_valid && in_ready;
   assign done       = (accept && !f_issue) || (disp_valid && disp_ready);

   always_comb begin
      state_d = state_q;
      if (accept && f_issue)          state_d = ST_ISSUE;
      else if (disp_valid && disp_ready) state_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         disp_opcode  <= '0;
         disp_flags   <= '0;
         disp_op0     <= '0;
         disp_op1     <= '0;
         disp_op2     <= '0;
         disp_vectors <= '0;
         disp_stride  <= '0;
      end else begin
         state_q <= state_d;
         if (accept && f_issue) begin
            disp_opcode  <= f_opcode;
            disp_flags   <= f_flags;
            disp_op0     <= f_op0;
            disp_op1     <= f_op1;
            disp_op2     <= f_op2;
            disp_vectors <= f_vectors;
            disp_stride  <= f_stride;
         end
      end
   end

   idec_regs #(
      .OP0_W(OP0_W), .CFG_W(CFG_W), .ATTR_W(ATTR_W), .TMO_W(TMO_W),
      .SAMPLE_W(SAMPLE_W), .OFF_SHIFT(OFF_SHIFT), .TMO_RESET(TMO_RESET),
      .TRACE_PIPE(TRACE_PIPE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(accept && f_config), .wr_addr(f_op0), .wr_data(f_op1[CFG_W-1:0]),
      .step(done),
      .dram0_base(dram0_base), .dram0_attr(dram0_cache),
      .dram1_base(dram1_base), .dram1_attr(dram1_cache),
      .stall_limit(stall_limit), .sample_period(sample_period),
      .pc(prog_count), .trace_hit(trace_flag)
   );

   idec_stall_watch #(.TMO_W(TMO_W)) u_watch (
      .clk(clk), .rst_n(rst_n), .state_chg(state_d != state_q),
      .limit(stall_limit), .flag(timeout_flag)
   );

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_ready |=> disp_valid && $stable(disp_opcode)
         && $stable(disp_flags) && $stable(disp_op0) && $stable(disp_op1)
         && $stable(disp_op2) && $stable(disp_vectors));
   p_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !f_issue |=> !disp_valid);
   p_stride_r11: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> $countones(disp_stride) == 1);
endmodule

// File: tb/tb_instr_decoder.sv
`timescale 1ns/1ps
module tb_instr_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_instr = '0;
   logic        disp_valid;
   logic        disp_ready = 1'b0;
   logic [3:0]  disp_opcode, disp_flags;
   logic [15:0] disp_op0;
   logic [31:0] disp_op1;
   logic [7:0]  disp_op2;
   logic [8:0]  disp_vectors;
   logic [7:0]  disp_stride;
   logic [47:0] dram0_base, dram1_base;
   logic [3:0]  dram0_cache, dram1_cache;
   logic [15:0] sample_period;
   logic [31:0] prog_count;
   logic        timeout_flag, trace_flag;

   int total = 0;
   int bad = 0;
   logic [31:0] exp_pc = '0;

   always #4 clk = ~clk;

   instr_decoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_instr(in_instr), .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_opcode(disp_opcode), .disp_flags(disp_flags), .disp_op0(disp_op0),
      .disp_op1(disp_op1), .disp_op2(disp_op2), .disp_vectors(disp_vectors),
      .disp_stride(disp_stride), .dram0_base(dram0_base), .dram0_cache(dram0_cache),
      .dram1_base(dram1_base), .dram1_cache(dram1_cache),
      .sample_period(sample_period), .prog_count(prog_count),
      .timeout_flag(timeout_flag), .trace_flag(trace_flag)
   );

   // entry: {instr[63:0], dispatched, vectors[8:0], stride[7:0]}
   localparam logic [81:0] VECS [0:8] = '{
      {4'h1, 4'h3, 8'h07, 32'h0000_0042, 16'h2005, 1'b1, 9'd8,   8'h02},
      {4'h2, 4'hD, 8'h00, 32'hDEAD_BEEF, 16'hE0FF, 1'b1, 9'd1,   8'h80},
      {4'h3, 4'h1, 8'h33, 32'h0000_00FF, 16'h0010, 1'b1, 9'd256, 8'h01},
      {4'h4, 4'h7, 8'h55, 32'h0000_1234, 16'h4001, 1'b1, 9'd1,   8'h04},
      {4'h5, 4'h0, 8'h01, 32'h0000_0003, 16'h6000, 1'b1, 9'd1,   8'h08},
      {4'h0, 4'h0, 8'h00, 32'h0000_0000, 16'h0000, 1'b0, 9'd0,   8'h00},
      {4'h6, 4'h5, 8'hAA, 32'h1111_2222, 16'h3333, 1'b0, 9'd0,   8'h00},
      {4'hE, 4'hF, 8'hFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, 9'd0,   8'h00},
      {4'h1, 4'h8, 8'hFF, 32'h0000_0001, 16'hA123, 1'b1, 9'd256, 8'h20}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic [3:0] op, input logic [3:0] fl,
                                      input logic [15:0] o0, input logic [31:0] o1,
                                      input logic [7:0] o2);
      return {op, fl, o2, o1, o0};
   endfunction

   task automatic send(input logic [63:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_instr = w;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic cfg(input logic [15:0] regn, input logic [31:0] val);
      send(mk(4'hF, 4'h0, regn, val, 8'h00));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R5 reset state
      @(negedge clk);
      check("R5 pc", 64'(prog_count), 64'h0);
      check("R5 dram0 base", 64'(dram0_base), 64'h0);
      check("R5 dram1 cache", 64'(dram1_cache), 64'h0);
      check("R5 sample", 64'(sample_period), 64'h0);
      check("R5 disp_valid", 64'(disp_valid), 64'h0);
      check("R5 in_ready", 64'(in_ready), 64'h1);
      check("R9 trace low at reset", 64'(trace_flag), 64'h0);
      // R8 default limit 100: edge count since reset release is 1 here
      repeat (48) @(negedge clk);
      check("R8 no timeout at 49 idle cycles", 64'(timeout_flag), 64'h0);
      repeat (56) @(negedge clk);
      check("R8 timeout after 105 idle cycles", 64'(timeout_flag), 64'h1);

      // R5 tracepoint default, R7 load and wrap
      cfg(16'h000A, 32'hFFFF_FFFF);
      check("R7 pc load no increment", 64'(prog_count), 64'hFFFF_FFFF);
      check("R5 R9 trace default all ones", 64'(trace_flag), 64'h1);
      send(mk(4'h0, 4'h0, 16'h0, 32'h0, 8'h0));
      check("R7 pc wraps", 64'(prog_count), 64'h0);
      check("R9 trace drops", 64'(trace_flag), 64'h0);
      exp_pc = 32'h0;

      // table of vectors: R1 R2 R3 R10 R11
      for (int i = 0; i < 9; i++) begin
         logic [63:0] w;
         logic        ed;
         logic [8:0]  ev;
         logic [7:0]  es;
         w  = VECS[i][81:18];
         ed = VECS[i][17];
         ev = VECS[i][16:8];
         es = VECS[i][7:0];
         send(w);
         if (ed) begin
            check("R2 dispatch offered", 64'(disp_valid), 64'h1);
            check("R2 input blocked", 64'(in_ready), 64'h0);
            check("R1 opcode", 64'(disp_opcode), 64'(w[63:60]));
            check("R1 flags", 64'(disp_flags), 64'(w[59:56]));
            check("R1 op2", 64'(disp_op2), 64'(w[55:48]));
            check("R1 op1", 64'(disp_op1), 64'(w[47:16]));
            check("R1 op0", 64'(disp_op0), 64'(w[15:0]));
            check("R10 vectors", 64'(disp_vectors), 64'(ev));
            check("R11 stride", 64'(disp_stride), 64'(es));
            check("R7 pc waits for handshake", 64'(prog_count), 64'(exp_pc));
            @(negedge clk);
            check("R2 held while not ready", 64'(disp_valid), 64'h1);
            check("R2 op1 stable", 64'(disp_op1), 64'(w[47:16]));
            disp_ready = 1'b1;
            @(negedge clk);
            disp_ready = 1'b0;
            exp_pc = exp_pc + 1;
            check("R2 offer retired", 64'(disp_valid), 64'h0);
            check("R7 pc after dispatch", 64'(prog_count), 64'(exp_pc));
         end else begin
            exp_pc = exp_pc + 1;
            check("R3 no dispatch", 64'(disp_valid), 64'h0);
            check("R3 local counted", 64'(prog_count), 64'(exp_pc));
         end
      end

      // R4 R6 configuration writes
      cfg(16'h0000, 32'h0000_0001);
      check("R6 dram0 base 64KiB unit", 64'(dram0_base), 64'h0001_0000);
      cfg(16'h0004, 32'h0000_ABCD);
      check("R6 dram1 base", 64'(dram1_base), 64'hABCD_0000);
      cfg(16'h0001, 32'h0000_0035);
      check("R4 dram0 cache truncated", 64'(dram0_cache), 64'h5);
      cfg(16'h0005, 32'h0000_000A);
      check("R4 dram1 cache", 64'(dram1_cache), 64'hA);
      cfg(16'h000B, 32'h0000_1234);
      check("R4 sample period", 64'(sample_period), 64'h1234);
      exp_pc = exp_pc + 5;
      check("R7 configure counts", 64'(prog_count), 64'(exp_pc));
      cfg(16'h0002, 32'hFFFF_FFFF);
      cfg(16'h000C, 32'hFFFF_FFFF);
      exp_pc = exp_pc + 2;
      check("R4 unused leaves dram0 base", 64'(dram0_base), 64'h0001_0000);
      check("R4 unused leaves dram1 base", 64'(dram1_base), 64'hABCD_0000);
      check("R4 unused leaves caches", 64'({dram0_cache, dram1_cache}), 64'h5A);
      check("R4 unused leaves sample", 64'(sample_period), 64'h1234);
      check("R4 unused only counts", 64'(prog_count), 64'(exp_pc));

      // R9 tracepoint match
      cfg(16'h000A, 32'h0000_1000);
      check("R7 pc loaded", 64'(prog_count), 64'h1000);
      cfg(16'h0009, 32'h0000_1003);
      send(mk(4'h0, 4'h0, 16'h0, 32'h0, 8'h0));
      check("R9 trace low before match", 64'(trace_flag), 64'h0);
      send(mk(4'h0, 4'h0, 16'h0, 32'h0, 8'h0));
      check("R9 trace at match", 64'(trace_flag), 64'h1);
      send(mk(4'h0, 4'h0, 16'h0, 32'h0, 8'h0));
      check("R9 trace after match", 64'(trace_flag), 64'h0);

      // R8 stall limit 5 on a held offer
      cfg(16'h0008, 32'h0000_0005);
      send(mk(4'h1, 4'h0, 16'h0, 32'h0, 8'h0));
      check("R8 cleared on state change", 64'(timeout_flag), 64'h0);
      repeat (4) @(negedge clk);
      check("R8 no flag at 4 cycles", 64'(timeout_flag), 64'h0);
      @(negedge clk);
      check("R8 flag at 5 cycles", 64'(timeout_flag), 64'h1);
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
      check("R8 flag drops on retire", 64'(timeout_flag), 64'h0);
      cfg(16'h0008, 32'h0000_0000);
      repeat (20) @(negedge clk);
      check("R8 limit zero disables", 64'(timeout_flag), 64'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule